// File: doc/BRIEF.md
# Misaligned Load Splitter with Byte-Order Select

This block sits between a core's load request port and a memory built from 32-bit words that are addressed in bytes. It accepts byte, half-word and word loads at any byte address. A load that stays inside one memory word costs one aligned read. A load whose bytes spill into the next word costs two aligned reads at consecutive word addresses. The block then picks out the requested bytes, orders them as big-endian or little-endian according to a mode input, and extends narrow results with zeros or with the sign bit.

A policy input can reject misaligned loads instead of serving them. A rejected load raises a one-cycle fault and starts no memory read. The block takes one request at a time. It raises `req_ready` only while idle. It holds the byte-order, sign and policy settings that were present when the request was accepted.

Top module: `load_align_unit`

## Requirements
- R1: `req_size` encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. In a memory word, byte lane k (bits 8k+7:8k) holds the byte at word base address + k. Every read the block issues is at an address whose two low bits are zero.
- R2: A load is misaligned when its address modulo its byte count is nonzero. With `trap_misalign` = 1, a misaligned load sets `fault` high for exactly the one cycle after the acceptance edge. It issues no memory read and produces no `resp_valid`.
- R3: Memory returns `mem_rd_data` in the cycle after `mem_rd_en`. A load whose bytes all lie in one word issues exactly one read. Misaligned loads of this kind are included. `resp_valid` rises in the cycle after the second clock edge following acceptance.
- R4: A load that crosses a word boundary issues exactly two reads, at word addresses W and W+4, on consecutive cycles. `resp_valid` rises in the cycle after the third clock edge following acceptance.
- R5: With `big_endian` = 1, the lowest-addressed byte is the most significant byte of the result. Bytes 00,00,02,03 at rising addresses give 515.
- R6: With `big_endian` = 0, the lowest-addressed byte is the least significant byte of the result. Bytes 03,02,00,00 at rising addresses give 515.
- R7: For 1- and 2-byte loads, `req_signed` = 1 fills the upper result bits with the most significant bit of the assembled value, and `req_signed` = 0 fills them with zeros. Word results are not changed by the setting.
- R8: `resp_valid` is high for a single cycle. `req_ready` is low from the cycle after acceptance of a served load until `resp_valid` has dropped. It stays high across a faulting load.
- R9: `big_endian`, `req_signed` and `trap_misalign` are sampled at acceptance. Changing them afterwards does not affect the result of the load in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | AW | Byte address of the load |
| req_size | input | 2 | Access width code (0, 1, 2) |
| req_signed | input | 1 | Sign-extend narrow results |
| big_endian | input | 1 | Byte-order select, 1 = big-endian |
| trap_misalign | input | 1 | Reject misaligned loads with a fault |
| mem_rd_en | output | 1 | Memory word read strobe |
| mem_rd_addr | output | AW | Word-aligned read address |
| mem_rd_data | input | DW | Read word, one cycle after the strobe |
| resp_valid | output | 1 | Load result valid, one cycle |
| resp_data | output | DW | Assembled, extended load result |
| fault | output | 1 | Misaligned load rejected |

## Verification
The acceptance edge is the reference point for all timing. A fault is due in the cycle right after that edge. A single-word result is due after two more edges, and a split result after three. The bench drives each request, then samples at every falling edge. It counts the edges until `resp_valid` appears and compares that count with the exact expected number, so an early or a late result both count as failures. The bench also counts the read strobes. It flips the mode inputs right after acceptance, and it checks that `resp_valid` and `req_ready` are in the expected state one edge after the response.

// File: rtl/load_align_pkg.sv
package load_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } ld_size_e;

  // byte count of a size code; an unused code is treated as a full word
  function automatic int size_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/load_seq_ctrl.sv
module load_seq_ctrl
  import load_align_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int OW = $clog2(NB),
  localparam int CW = OW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_signed,
  input  logic          big_endian,
  input  logic          trap_misalign,
  output logic          req_ready,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic [DW-1:0] lo_word,
  output logic [DW-1:0] hi_word,
  output logic [OW-1:0] byte_off,
  output logic [CW-1:0] byte_cnt,
  output logic          sgn_sel,
  output logic          big_sel,
  output logic          resp_valid,
  output logic          fault
);

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_CAP_LO, S_CAP_HI, S_RESP
  } seq_state_e;

  seq_state_e state_q, state_d;
  logic          fault_q, fault_d;
  logic          acc_en, lo_en, hi_en;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          sgn_q, big_q, split_q;
  logic [DW-1:0] lo_q, hi_q;

  logic [OW-1:0] off_in;
  logic [CW-1:0] cnt_in;
  logic          misal_in, cross_in;
  logic          hi_sel;

  assign off_in   = req_addr[OW-1:0];
  assign cnt_in   = CW'(size_bytes(req_size));
  assign misal_in = |(off_in & OW'(cnt_in - CW'(1)));
  assign cross_in = ({1'b0, off_in} + cnt_in) > CW'(NB);

  // next-state and strobe logic
  always_comb begin
    state_d   = state_q;
    fault_d   = 1'b0;
    acc_en    = 1'b0;
    lo_en     = 1'b0;
    hi_en     = 1'b0;
    mem_rd_en = 1'b0;
    hi_sel    = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          if (misal_in && trap_misalign) begin
            fault_d = 1'b1;
          end else begin
            acc_en  = 1'b1;
            state_d = S_ISSUE;
          end
        end
      end
      S_ISSUE: begin
        mem_rd_en = 1'b1;
        state_d   = S_CAP_LO;
      end
      S_CAP_LO: begin
        lo_en = 1'b1;
        if (split_q) begin
          mem_rd_en = 1'b1;
          hi_sel    = 1'b1;
          state_d   = S_CAP_HI;
        end else begin
          state_d = S_RESP;
        end
      end
      S_CAP_HI: begin
        hi_en   = 1'b1;
        state_d = S_RESP;
      end
      S_RESP:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
    end
  end

  // datapath registers, enabled only
  always_ff @(posedge clk) begin
    if (acc_en) begin
      addr_q  <= req_addr;
      cnt_q   <= cnt_in;
      sgn_q   <= req_signed;
      big_q   <= big_endian;
      split_q <= cross_in;
    end
    if (lo_en) lo_q <= mem_rd_data;
    if (hi_en) hi_q <= mem_rd_data;
  end

  assign mem_rd_addr = {addr_q[AW-1:OW] + {{(AW-OW-1){1'b0}}, hi_sel}, {OW{1'b0}}};
  assign req_ready   = (state_q == S_IDLE);
  assign resp_valid  = (state_q == S_RESP);
  assign fault       = fault_q;
  assign lo_word     = lo_q;
  assign hi_word     = hi_q;
  assign byte_off    = addr_q[OW-1:0];
  assign byte_cnt    = cnt_q;
  assign sgn_sel     = sgn_q;
  assign big_sel     = big_q;

endmodule

// File: rtl/byte_merge.sv
module byte_merge #(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int OW = $clog2(NB),
  localparam int CW = OW + 1
) (
  input  logic [DW-1:0] lo_word,
  input  logic [DW-1:0] hi_word,
  input  logic [OW-1:0] byte_off,
  input  logic [CW-1:0] byte_cnt,
  input  logic          sgn_sel,
  input  logic          big_sel,
  output logic [DW-1:0] data
);

  logic [2*DW-1:0] window;
  logic [DW-1:0]   ordered;
  logic            top_bit;

  // bytes in address order, starting at the requested byte
  assign window = {hi_word, lo_word} >> {byte_off, 3'b000};

  always_comb begin
    int n;
    n       = int'(byte_cnt);
    ordered = '0;
    for (int i = 0; i < NB; i++) begin
      if (i < n) begin
        if (big_sel) ordered[8*(n-1-i) +: 8] = window[8*i +: 8];
        else         ordered[8*i +: 8]       = window[8*i +: 8];
      end
    end
    top_bit = ordered[8*n-1];
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    localparam logic [CW-1:0] LANE = CW'(g);
    assign data[8*g +: 8] = (LANE < byte_cnt) ? ordered[8*g +: 8]
                                              : {8{sgn_sel & top_bit}};
  end

endmodule

// File: rtl/load_align_unit.sv
module load_align_unit #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_signed,
  input  logic          big_endian,
  input  logic          trap_misalign,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data,
  output logic          fault
);

  localparam int NB = DW / 8;
  localparam int OW = $clog2(NB);
  localparam int CW = OW + 1;

  logic [DW-1:0] lo_word, hi_word;
  logic [OW-1:0] byte_off;
  logic [CW-1:0] byte_cnt;
  logic          sgn_sel, big_sel;

  load_seq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .req_signed    (req_signed),
    .big_endian    (big_endian),
    .trap_misalign (trap_misalign),
    .req_ready     (req_ready),
    .mem_rd_en     (mem_rd_en),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rd_data   (mem_rd_data),
    .lo_word       (lo_word),
    .hi_word       (hi_word),
    .byte_off      (byte_off),
    .byte_cnt      (byte_cnt),
    .sgn_sel       (sgn_sel),
    .big_sel       (big_sel),
    .resp_valid    (resp_valid),
    .fault         (fault)
  );

  byte_merge #(.DW(DW)) u_merge (
    .lo_word  (lo_word),
    .hi_word  (hi_word),
    .byte_off (byte_off),
    .byte_cnt (byte_cnt),
    .sgn_sel  (sgn_sel),
    .big_sel  (big_sel),
    .data     (resp_data)
  );

endmodule

// File: rtl/load_align_unit_chk.sv
module load_align_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_off,
  input logic [1:0]    req_size,
  input logic          trap_misalign,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_rd_addr,
  input logic          resp_valid,
  input logic          fault
);

  logic misal;
  assign misal = (req_size == 2'd1) ? req_off[0]
               : (req_size == 2'd0) ? 1'b0 : (req_off != 2'b00);

  // R1
  aligned_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr[1:0] == 2'b00));

  // R2
  trap_raises_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && misal && trap_misalign) |=> fault);

  // R2
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!mem_rd_en && !resp_valid));

  // R4
  second_read_next_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + AW'(4)));

  // R3
  no_result_under_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !resp_valid);

  // R8
  resp_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);

endmodule

bind load_align_unit load_align_unit_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_off       (req_addr[1:0]),
  .req_size      (req_size),
  .trap_misalign (trap_misalign),
  .mem_rd_en     (mem_rd_en),
  .mem_rd_addr   (mem_rd_addr),
  .resp_valid    (resp_valid),
  .fault         (fault)
);

// File: tb/tb_load_align_unit.sv
module tb_load_align_unit;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic          req_signed;
  logic          big_endian;
  logic          trap_misalign;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data;
  logic          resp_valid;
  logic [DW-1:0] resp_data;
  logic          fault;

  logic [7:0] mem_b [64];
  int rd_cnt;
  int checks;
  int errors;

  load_align_unit #(.AW(AW), .DW(DW)) dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory with one-cycle read latency; lane k holds byte base+k (R1)
  always @(posedge clk) begin
    if (mem_rd_en) begin
      int b;
      b = {26'd0, mem_rd_addr[5:2], 2'b00};
      mem_rd_data <= {mem_b[b+3], mem_b[b+2], mem_b[b+1], mem_b[b]};
      rd_cnt = rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_val(input int a, input int sz, input bit sgn,
                                          input bit big);
    int n;
    logic [31:0] v;
    n = 1 << sz;
    v = '0;
    for (int i = 0; i < n; i++) begin
      if (big) v = (v << 8) | {24'd0, mem_b[(a+i) & 63]};
      else     v[8*i +: 8] = mem_b[(a+i) & 63];
    end
    if (sgn && n < 4 && v[8*n-1])
      for (int j = n; j < 4; j++) v[8*j +: 8] = 8'hFF;
    return v;
  endfunction

  task automatic do_load(input int a, input int sz, input bit sgn, input bit big,
                         input bit trap);
    int n;
    bit mis, split, got;
    logic [31:0] exp;
    string tag;
    n     = 1 << sz;
    mis   = (a % n) != 0;
    split = ((a % 4) + n) > 4;
    exp   = exp_val(a, sz, sgn, big);
    tag   = (sgn && n < 4) ? "R7" : (big ? "R5" : "R6");
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(a); req_size = 2'(sz);
    req_signed = sgn; big_endian = big; trap_misalign = trap;
    rd_cnt = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R9: settings change after acceptance
    big_endian = ~big; req_signed = ~sgn; trap_misalign = ~trap;
    if (mis && trap) begin
      chk(fault == 1'b1, "R2 fault raised", 32'(fault), 32'd1);
      chk(req_ready == 1'b1, "R8 ready on fault", 32'(req_ready), 32'd1);
      @(posedge clk); @(negedge clk);
      chk(fault == 1'b0, "R2 fault one cycle", 32'(fault), 32'd0);
      repeat (3) begin
        @(posedge clk); @(negedge clk);
        chk(resp_valid == 1'b0, "R2 no response", 32'(resp_valid), 32'd0);
      end
      chk(rd_cnt == 0, "R2 no reads", 32'(rd_cnt), 32'd0);
    end else begin
      chk(fault == 1'b0, "R2 no fault", 32'(fault), 32'd0);
      chk(req_ready == 1'b0, "R8 busy", 32'(req_ready), 32'd0);
      n = 0; got = 1'b0;
      while (n < 6 && !got) begin
        @(posedge clk); @(negedge clk);
        n++;
        if (resp_valid) got = 1'b1;
      end
      if (split) begin
        chk(n == 3, "R4 latency", 32'(n), 32'd3);
        chk(rd_cnt == 2, "R4 two reads", 32'(rd_cnt), 32'd2);
      end else begin
        chk(n == 2, "R3 latency", 32'(n), 32'd2);
        chk(rd_cnt == 1, "R3 one read", 32'(rd_cnt), 32'd1);
      end
      chk(resp_data == exp, {tag, " R9 data"}, resp_data, exp);
      @(posedge clk); @(negedge clk);
      chk(resp_valid == 1'b0, "R8 single pulse", 32'(resp_valid), 32'd0);
      chk(req_ready == 1'b1, "R8 ready again", 32'(req_ready), 32'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2417));
    checks = 0; errors = 0; rd_cnt = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
    req_signed = 1'b0; big_endian = 1'b0; trap_misalign = 1'b0;
    mem_rd_data = '0;
    for (int i = 0; i < 64; i++) mem_b[i] = 8'($urandom);
    // directed patterns
    mem_b[16] = 8'h00; mem_b[17] = 8'h00; mem_b[18] = 8'h02; mem_b[19] = 8'h03;
    mem_b[24] = 8'h03; mem_b[25] = 8'h02; mem_b[26] = 8'h00; mem_b[27] = 8'h00;
    mem_b[32] = 8'h80; mem_b[33] = 8'hF1; mem_b[34] = 8'h7F; mem_b[35] = 8'h9C;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(resp_valid == 1'b0, "R8 reset resp", 32'(resp_valid), 32'd0);
    chk(fault == 1'b0, "R2 reset fault", 32'(fault), 32'd0);
    chk(mem_rd_en == 1'b0, "R1 reset read", 32'(mem_rd_en), 32'd0);
    chk(req_ready == 1'b1, "R8 reset ready", 32'(req_ready), 32'd1);

    // R5 / R6 value 515 in each order
    do_load(16, 2, 1'b0, 1'b1, 1'b0);
    chk(exp_val(16, 2, 1'b0, 1'b1) == 32'd515, "R5 model", exp_val(16, 2, 1'b0, 1'b1), 32'd515);
    do_load(24, 2, 1'b0, 1'b0, 1'b0);
    chk(exp_val(24, 2, 1'b0, 1'b0) == 32'd515, "R6 model", exp_val(24, 2, 1'b0, 1'b0), 32'd515);
    // R7 sign and zero fill
    do_load(32, 0, 1'b1, 1'b0, 1'b0);
    do_load(32, 0, 1'b0, 1'b0, 1'b0);
    do_load(33, 1, 1'b1, 1'b1, 1'b0);
    do_load(34, 1, 1'b1, 1'b0, 1'b0);
    // R3 misaligned in-word half, R4 crossing half and word
    do_load(17, 1, 1'b0, 1'b1, 1'b0);
    do_load(19, 1, 1'b0, 1'b0, 1'b0);
    do_load(18, 2, 1'b0, 1'b1, 1'b0);
    do_load(31, 2, 1'b1, 1'b0, 1'b0);
    // R2 trap, and aligned requests with trap enabled
    do_load(17, 1, 1'b0, 1'b0, 1'b1);
    do_load(21, 2, 1'b0, 1'b1, 1'b1);
    do_load(20, 2, 1'b0, 1'b1, 1'b1);
    do_load(13, 0, 1'b1, 1'b0, 1'b1);

    for (int k = 0; k < 300; k++) begin
      int a, sz;
      a  = int'($urandom_range(0, 55));
      sz = int'($urandom_range(0, 2));
      do_load(a, sz, 1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule